// File: doc/BRIEF.md
# Two-Class Weighted / Strict-Priority Command Arbiter

This block sits in front of a transmit command pipeline and chooses, each clock cycle, which of two class-of-service command queues (class 0 and class 1) may hand over one command. Each queue offers a command with a valid/ready handshake and states the command's cost on a length input. The arbiter raises at most one ready per cycle. One cycle later it reports the granted class and the cost on registered outputs.

A small register file holds the settings. Software writes it through a one-cycle write strobe, an address and a data word. Two modes are available. In weighted mode, each class holds a signed credit. When no requesting class has positive credit, the credit is topped up by that class's weight, but never beyond that class's ceiling. The class with more credit wins, and each grant charges the winner for the command's cost. In priority mode the credits are not used. A chosen high class wins a programmable number of consecutive decisions. After that comes one round-robin decision whose first choice alternates. With a count of zero, the mode becomes plain round robin. In both modes a class that is the only requester is always served.

Top module: `ets_cmd_arbiter`

## Requirements
- R1: After synchronous reset, `grant_valid` is 0, all credits are 0, priority mode is selected with a strict-slot count of 0, weights and ceilings are 0, and the first round-robin decision favours class 0.
- R2: In every cycle at most one of `cos0_ready`/`cos1_ready` is 1. Ready is only given to a class whose valid is 1. Whenever any valid is 1, exactly one ready is 1, and a lone requester is always the one served, in both modes.
- R3: The cycle after a handshake, `grant_valid` is 1, `grant_cos` holds the served class (0 or 1), and `grant_len` holds that class's length input. Otherwise `grant_valid` is 0.
- R4: A write with `cfg_we`=1 stores `cfg_wdata` as follows. Address 0 holds the class 0 weight and address 1 the class 1 weight, both bits [WW-1:0]. Address 2 holds the class 0 ceiling and address 3 the class 1 ceiling, also bits [WW-1:0]. Address 4 is the mode, where bit 0 = 1 selects weighted mode. Address 5 holds the high class in bit 0. Address 6 holds the strict-slot count N in bits [SW-1:0].
- R5: In priority mode, while fewer than N grants have passed since the last round-robin decision, a contested decision goes to the high class. The next grant is a round-robin decision, and after it the count restarts. Every grant counts, including uncontested ones.
- R6: Every round-robin decision flips its first choice for the next one, starting with class 0 after reset. With N=0 every decision is round robin, so contested requests alternate.
- R7: The high-class register selects which class wins the strict decisions.
- R8: In weighted mode, when a grant happens and no requesting class has credit above 0, both credits first become min(credit + weight, ceiling) before the decision.
- R9: In weighted mode, a contested decision goes to the larger credit, and a tie goes to the class that was not served by the previous grant. The winner's credit then drops by its length, with a floor of -2^WW.
- R10: In priority mode the credits neither change nor affect the decision.
- R11: A configuration write takes effect at the decision in the cycle right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cos0_valid | input | 1 | Class 0 command offered |
| cos0_len | input | LW | Class 0 command cost |
| cos0_ready | output | 1 | Class 0 command accepted this cycle |
| cos1_valid | input | 1 | Class 1 command offered |
| cos1_len | input | LW | Class 1 command cost |
| cos1_ready | output | 1 | Class 1 command accepted this cycle |
| grant_valid | output | 1 | A grant happened in the previous cycle |
| grant_cos | output | 1 | Class of that grant |
| grant_len | output | LW | Cost of that grant |

## Verification
The ready outputs are combinational, so they are compared in the same cycle, one time unit after the bench changes the valid and length inputs at the falling edge. The grant outputs pass through one register, so they are compared one time unit after the following rising edge, against the winner the bench model predicted for that cycle. Configuration writes land at a rising edge, and the next cycle is already checked against the new settings. The bench model updates its credits, slot counter and round-robin pointer at the same rising edge as the design.

// File: rtl/ets_arb_pkg.sv
package ets_arb_pkg;
  localparam int NCLS = 2;

  typedef enum logic [2:0] {
    SEL_WEIGHT0 = 3'd0,
    SEL_WEIGHT1 = 3'd1,
    SEL_CEIL0   = 3'd2,
    SEL_CEIL1   = 3'd3,
    SEL_MODE    = 3'd4,
    SEL_HIGH    = 3'd5,
    SEL_SLOTS   = 3'd6
  } cfg_sel_e;
endpackage

// File: rtl/ets_cfg_regs.sv
module ets_cfg_regs
  import ets_arb_pkg::*;
#(
  parameter int WW = 31,
  parameter int SW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [NCLS-1:0][WW-1:0]  weight,
  output logic [NCLS-1:0][WW-1:0]  ceil,
  output logic                     wfq_en,
  output logic                     high_cls,
  output logic [SW-1:0]            slots
);
  always_ff @(posedge clk) begin
    if (rst) begin
      weight   <= '0;
      ceil     <= '0;
      wfq_en   <= 1'b0;
      high_cls <= 1'b0;
      slots    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_addr))
        SEL_WEIGHT0: weight[0] <= cfg_wdata[WW-1:0];
        SEL_WEIGHT1: weight[1] <= cfg_wdata[WW-1:0];
        SEL_CEIL0:   ceil[0]   <= cfg_wdata[WW-1:0];
        SEL_CEIL1:   ceil[1]   <= cfg_wdata[WW-1:0];
        SEL_MODE:    wfq_en    <= cfg_wdata[0];
        SEL_HIGH:    high_cls  <= cfg_wdata[0];
        SEL_SLOTS:   slots     <= cfg_wdata[SW-1:0];
        default: ;
      endcase
    end
  end

  // R4: a mode write lands in the register at the next edge
  assert_mode_write_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 3'd4) |=> (wfq_en == $past(cfg_wdata[0])));
endmodule

// File: rtl/ets_credit_bank.sv
module ets_credit_bank
  import ets_arb_pkg::*;
#(
  parameter int WW = 31,
  parameter int LW = 16,
  localparam int CW = WW + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wfq_en,
  input  logic                     fire,
  input  logic                     win,
  input  logic [LW-1:0]            win_len,
  input  logic [NCLS-1:0]          valid,
  input  logic [NCLS-1:0][WW-1:0]  weight,
  input  logic [NCLS-1:0][WW-1:0]  ceil,
  output logic [NCLS-1:0][CW-1:0]  eff_credit
);
  localparam logic signed [CW-1:0] FLOOR = {2'b11, {WW{1'b0}}};

  logic signed [CW-1:0] cred_q [NCLS];
  logic [NCLS-1:0]      positive;
  logic                 refill;

  always_comb begin
    for (int c = 0; c < NCLS; c++) positive[c] = (cred_q[c] > 0);
  end
  assign refill = wfq_en && ((valid & positive) == '0);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic signed [CW-1:0] sum, bnd, capped, eff, charged;
    assign bnd     = $signed({2'b00, ceil[c]});
    assign sum     = cred_q[c] + $signed({2'b00, weight[c]});
    assign capped  = (sum > bnd) ? bnd : sum;
    assign eff     = refill ? capped : cred_q[c];
    assign charged = eff - $signed({{(CW-LW){1'b0}}, win_len});
    assign eff_credit[c] = eff;

    always_ff @(posedge clk) begin
      if (rst) cred_q[c] <= '0;
      else if (fire && wfq_en) begin
        if (win == 1'(c)) cred_q[c] <= (charged < FLOOR) ? FLOOR : charged;
        else              cred_q[c] <= eff;
      end
    end

    // R8: after a refill decision no credit exceeds its ceiling
    assert_capped_R8: assert property (@(posedge clk) disable iff (rst)
      (fire && refill) |=> (cred_q[c] <= $past(bnd)));
    // R10: credits frozen in priority mode
    assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
      !wfq_en |=> (cred_q[c] == $past(cred_q[c])));
  end
endmodule

// File: rtl/ets_strict_sched.sv
module ets_strict_sched #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [SW-1:0] slots,
  output logic          rr_slot,
  output logic          rr_first
);
  logic [SW-1:0] cnt;

  assign rr_slot = (cnt >= slots);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      rr_first <= 1'b0;
    end else if (adv) begin
      if (rr_slot) begin
        cnt      <= '0;
        rr_first <= ~rr_first;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5: a strict grant moves the slot count on by one
  assert_slot_count_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && !rr_slot) |=> (cnt == $past(cnt) + 1'b1));
  // R6: a round-robin grant flips the first choice and restarts the count
  assert_rr_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && rr_slot) |=> (rr_first != $past(rr_first) && cnt == '0));
endmodule

// File: rtl/ets_cmd_arbiter.sv
module ets_cmd_arbiter
  import ets_arb_pkg::*;
#(
  parameter int WW = 31,
  parameter int LW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          cos0_valid,
  input  logic [LW-1:0] cos0_len,
  output logic          cos0_ready,
  input  logic          cos1_valid,
  input  logic [LW-1:0] cos1_len,
  output logic          cos1_ready,
  output logic          grant_valid,
  output logic          grant_cos,
  output logic [LW-1:0] grant_len
);
  localparam int CW = WW + 2;

  logic [NCLS-1:0][WW-1:0] weight, ceil;
  logic [NCLS-1:0][CW-1:0] eff;
  logic                    wfq_en, high_cls, rr_slot, rr_first;
  logic [SW-1:0]           slots;
  logic [NCLS-1:0]         valid, ready;
  logic                    fire, win, last_win;
  logic [LW-1:0]           win_len;
  logic [31:0]             unused_wdata;

  assign unused_wdata = cfg_wdata;
  assign valid = {cos1_valid, cos0_valid};
  assign fire  = |valid;

  ets_cfg_regs #(.WW(WW), .SW(SW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .weight(weight), .ceil(ceil),
    .wfq_en(wfq_en), .high_cls(high_cls), .slots(slots)
  );

  ets_credit_bank #(.WW(WW), .LW(LW)) u_credit (
    .clk(clk), .rst(rst), .wfq_en(wfq_en), .fire(fire), .win(win),
    .win_len(win_len), .valid(valid), .weight(weight), .ceil(ceil),
    .eff_credit(eff)
  );

  ets_strict_sched #(.SW(SW)) u_sched (
    .clk(clk), .rst(rst), .adv(fire && !wfq_en), .slots(slots),
    .rr_slot(rr_slot), .rr_first(rr_first)
  );

  always_comb begin
    if (!valid[1])      win = 1'b0;
    else if (!valid[0]) win = 1'b1;
    else if (wfq_en) begin
      if ($signed(eff[0]) > $signed(eff[1]))      win = 1'b0;
      else if ($signed(eff[1]) > $signed(eff[0])) win = 1'b1;
      else                                        win = ~last_win;
    end else begin
      win = rr_slot ? rr_first : high_cls;
    end
  end

  assign win_len = win ? cos1_len : cos0_len;
  assign ready   = fire ? (win ? 2'b10 : 2'b01) : 2'b00;
  assign cos0_ready = ready[0];
  assign cos1_ready = ready[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_cos   <= 1'b0;
      grant_len   <= '0;
      last_win    <= 1'b1;
    end else begin
      grant_valid <= fire;
      if (fire) begin
        grant_cos <= win;
        grant_len <= win_len;
        last_win  <= win;
      end
    end
  end

  // R2: ready is exclusive and only offered to a requester
  assert_ready_legal_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ready) && ((ready & ~valid) == 2'b00));
  // R2: work conserving
  assert_work_conserving_R2: assert property (@(posedge clk) disable iff (rst)
    (|valid) |-> (|ready));
  // R3: a handshake is reported on the next cycle
  assert_grant_report_R3: assert property (@(posedge clk) disable iff (rst)
    (|ready) |=> (grant_valid && grant_cos == $past(ready[1])));
  assert_idle_report_R3: assert property (@(posedge clk) disable iff (rst)
    !(|valid) |=> !grant_valid);
endmodule

// File: tb/ets_cmd_arbiter_test.sv
`timescale 1ns/1ps
module ets_cmd_arbiter_test;
  localparam int LW = 16;
  localparam longint FLOORV = -(64'sd1 <<< 31);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic cos0_valid = 1'b0, cos1_valid = 1'b0;
  logic [LW-1:0] cos0_len = '0, cos1_len = '0;
  logic cos0_ready, cos1_ready, grant_valid, grant_cos;
  logic [LW-1:0] grant_len;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of the settings and state
  longint m_w [2], m_b [2], m_cred [2];
  bit m_wfq, m_hi, m_ptr, m_last;
  int m_n, m_cnt;

  always #2 clk = ~clk;

  ets_cmd_arbiter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cos0_valid(cos0_valid), .cos0_len(cos0_len),
    .cos0_ready(cos0_ready), .cos1_valid(cos1_valid), .cos1_len(cos1_len),
    .cos1_ready(cos1_ready), .grant_valid(grant_valid),
    .grant_cos(grant_cos), .grant_len(grant_len)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_w = '{0, 0}; m_b = '{0, 0}; m_cred = '{0, 0};
    m_wfq = 0; m_hi = 0; m_ptr = 0; m_last = 1; m_n = 0; m_cnt = 0;
  endtask

  function automatic longint capped(input longint c, input longint w, input longint b);
    return (c + w > b) ? b : c + w;
  endfunction

  task automatic cfg_write(input int addr, input longint data);
    @(negedge clk);
    cos0_valid = 0; cos1_valid = 0;
    cfg_we = 1; cfg_addr = 3'(addr); cfg_wdata = 32'(data);
    @(posedge clk);
    case (addr)
      0: m_w[0] = data & 32'h7fff_ffff;
      1: m_w[1] = data & 32'h7fff_ffff;
      2: m_b[0] = data & 32'h7fff_ffff;
      3: m_b[1] = data & 32'h7fff_ffff;
      4: m_wfq  = data[0];
      5: m_hi   = data[0];
      6: m_n    = int'(data & 16'hffff);
      default: ;
    endcase
    #1 cfg_we = 0;
  endtask

  // one arbitration cycle, ready then grant checked
  task automatic cycle(input bit v0, input bit v1, input int l0, input int l1, input string tag);
    bit fire, win, rf;
    longint e0, e1, lw;
    @(negedge clk);
    cos0_valid = v0; cos1_valid = v1;
    cos0_len = LW'(l0); cos1_len = LW'(l1);
    fire = v0 | v1;
    e0 = m_cred[0]; e1 = m_cred[1];
    rf = m_wfq && !((v0 && m_cred[0] > 0) || (v1 && m_cred[1] > 0));
    if (rf) begin
      e0 = capped(m_cred[0], m_w[0], m_b[0]);
      e1 = capped(m_cred[1], m_w[1], m_b[1]);
    end
    if (!v1) win = 0;
    else if (!v0) win = 1;
    else if (m_wfq) win = (e0 > e1) ? 0 : (e1 > e0) ? 1 : !m_last;
    else win = (m_cnt >= m_n) ? m_ptr : m_hi;
    #1;
    check({cos1_ready, cos0_ready} == (fire ? (win ? 2'b10 : 2'b01) : 2'b00),
          {tag, " ready"}, {cos1_ready, cos0_ready},
          fire ? (win ? 2 : 1) : 0);
    @(posedge clk);
    if (fire) begin
      lw = win ? l1 : l0;
      if (m_wfq) begin
        m_cred[0] = e0; m_cred[1] = e1;
        m_cred[win] = (m_cred[win] - lw < FLOORV) ? FLOORV : m_cred[win] - lw;
      end else if (m_cnt >= m_n) begin
        m_cnt = 0; m_ptr = !m_ptr;
      end else m_cnt++;
      m_last = win;
    end
    #1;
    if (fire)
      check(grant_valid && grant_cos == win && grant_len == LW'(win ? l1 : l0),
            "R3 grant", {grant_valid, grant_cos, 16'(grant_len)},
            {1'b1, win, 16'(win ? l1 : l0)});
    else
      check(!grant_valid, "R3 idle", grant_valid, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #1 check(!grant_valid, "R1 reset grant_valid", grant_valid, 0);
    // R1: priority mode, N=0, round robin starts with class 0
    cycle(1, 1, 4, 5, "R1 first decision");
    cycle(1, 1, 4, 5, "R6 alternate");
    cycle(1, 1, 4, 5, "R6 alternate");
    cycle(0, 0, 0, 0, "R2 idle");
    cycle(0, 1, 9, 7, "R2 lone class1");
    cycle(1, 0, 3, 7, "R2 lone class0");

    // R4/R5/R7/R11: strict with N=3, high class 1
    cfg_write(5, 1);
    cfg_write(6, 3);
    cycle(1, 1, 1, 2, "R11 first after write");
    for (int i = 0; i < 10; i++) cycle(1, 1, i, i + 1, "R5 strict pattern");
    cfg_write(5, 0);
    for (int i = 0; i < 8; i++) cycle(1, 1, 2, 3, "R7 high class 0");

    // R10: weights in priority mode have no effect, credits stay zero
    cfg_write(0, 7); cfg_write(1, 3); cfg_write(2, 20); cfg_write(3, 20);
    for (int i = 0; i < 6; i++) cycle(1, 1, 5, 5, "R10 weights unused");
    cfg_write(4, 1);
    // R8/R9: weighted mode starting from zero credit
    cycle(1, 1, 4, 4, "R10 credits untouched R8 refill");
    for (int i = 0; i < 12; i++) cycle(1, 1, 4, 2, "R9 weighted");
    cfg_write(2, 3);
    for (int i = 0; i < 6; i++) cycle(1, 1, 1, 1, "R8 ceiling cap");
    cfg_write(0, 0); cfg_write(1, 0);
    for (int i = 0; i < 4; i++) cycle(1, 0, 60000, 0, "R9 floor");
    cycle(1, 1, 0, 0, "R9 tie");

    // random phases
    for (int p = 0; p < 6; p++) begin
      cfg_write(0, $urandom_range(60)); cfg_write(1, $urandom_range(60));
      cfg_write(2, $urandom_range(200)); cfg_write(3, $urandom_range(200));
      cfg_write(4, p % 2); cfg_write(5, $urandom_range(1));
      cfg_write(6, $urandom_range(4));
      for (int i = 0; i < 1500; i++) begin
        bit a, b;
        a = ($urandom_range(3) != 0); b = ($urandom_range(3) != 0);
        cycle(a, b, $urandom_range(40), $urandom_range(40),
              (p % 2) ? "R9 random weighted" : "R5 random strict");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule